// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-division switch for 384 channels of 8-bit samples, each channel carrying one sample per 8 kHz frame (64 kbit/s). Channels 0 to 255 belong to the shared bus side and channels 256 to 383 to the local side. An upstream deserializer presents one input sample per channel slot together with a slot strobe. The switch keeps one byte per input channel in a data memory. For every output channel it builds one output beat from a 12-bit connection word. That word either points at a data-memory byte (connection mode) or supplies a constant byte (message mode), and it also gates the output driver.

A synchronous processor port reads and writes the data memory, the connection memory and a global output-enable register while switching continues. Switching traffic owns the memories in strobe cycles. A processor request raised in such a cycle waits on a ready handshake until a cycle without a strobe.

Top module: `tsi_switch`

## Requirements
- R1: A slot counter starts at 0 after reset and advances by one on each cycle with `in_strobe` high, wrapping from 383 to 0. One cycle after a strobe, `out_slot` is high and `out_chan` carries the served channel. `out_sof` is high only when that channel is 0. In cycles without a strobe, `out_slot` and `out_valid` are low.
- R2: The `in_sample` byte present in a strobe cycle is stored at the data-memory address equal to the served channel.
- R3: In connection mode, the output byte for channel N is the data-memory byte at the pointer, as it stood before the input write of that same strobe. A pointer below N therefore yields the current frame's sample, and a pointer at or above N yields the previous frame's sample.
- R4: Connection word layout: bits 8..0 are the pointer, bit 9 is driver enable (1 = drive), bit 10 is message mode (1 = message), and bit 11 is an auxiliary control bit that appears on `out_aux` while the slot is driven.
- R5: In message mode the output byte is bits 7..0 of the connection word.
- R6: When the word's driver-enable bit is 0, or the global enable is 0, the slot gives `out_valid` = 0, `out_data` = 0 and `out_aux` = 0.
- R7: A connection-mode pointer of 384 or more gives output byte 0x00, with `out_valid` still set by R6.
- R8: Processor targets are selected by `cpu_sel`: 0 = data memory (bits 7..0, read zero-extended), 1 = connection memory (12 bits), 2 = global enable (bit 0). `cpu_ready` is high in any cycle with `cpu_req` high and `in_strobe` low. The access takes place at that edge, and read data appears on `cpu_rdata` in the next cycle.
- R9: In a cycle with `in_strobe` high, `cpu_ready` is low and the processor access does not happen. The request is served in the first cycle without a strobe.
- R10: A processor write to a data-memory byte is replaced by the next input sample of that channel. A processor write to a connection word governs that channel's next strobe.
- R11: Reset clears both memories, the global enable, the slot counter and all outputs.
- R12: `out_local` is high exactly when the served channel is 256 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Channel slot strobe from the deserializer |
| in_sample | input | 8 | Input sample of the current slot |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 2 | Target: 0 data, 1 connection, 2 enable |
| cpu_addr | input | 9 | Memory address |
| cpu_wdata | input | 12 | Write data |
| cpu_ready | output | 1 | Access accepted this cycle |
| cpu_rdata | output | 12 | Read data, one cycle after acceptance |
| out_slot | output | 1 | Output beat present |
| out_valid | output | 1 | Driver enabled for this beat |
| out_chan | output | 9 | Output channel of this beat |
| out_sof | output | 1 | Beat is channel 0 |
| out_local | output | 1 | Beat belongs to the local group |
| out_aux | output | 1 | Auxiliary control bit of the word |
| out_data | output | 8 | Output sample |

## Verification
A corrupted connection word or data byte shows up on `out_data`, `out_valid` or `out_aux` in the cycle after the affected channel's next strobe, so in the worst case within one frame. A slip in the slot counter shows up on `out_chan` and `out_sof` at the very next beat. Broken arbitration shows up on `cpu_ready` in the same cycle, and as a wrong value in the next read-back. Because the read-before-write order decides whether a pointer returns the current frame's sample or the previous one, the bench places pointers on both sides of the channel and equal to it.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int CH_TOTAL = 384;
    localparam int CH_BUS   = 256;
    localparam int PTR_W    = 9;
    localparam int SMP_W    = 8;
    localparam int CWORD_W  = 12;

    typedef logic [PTR_W-1:0] chan_t;
    typedef logic [SMP_W-1:0] sample_t;

    typedef struct packed {
        logic  aux;
        logic  msg;
        logic  drv;
        chan_t ptr;
    } conn_word_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CONN = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cpu_sel_e;

    typedef struct packed {
        logic    slot;
        logic    valid;
        logic    sof;
        logic    local_ch;
        logic    aux;
        chan_t   chan;
        sample_t data;
    } out_beat_t;

    function automatic out_beat_t make_beat(
        input logic       slot,
        input chan_t      ch,
        input conn_word_t w,
        input sample_t    mem_byte,
        input logic       ptr_ok,
        input logic       gen_en,
        input logic       is_local
    );
        out_beat_t b;
        logic en;
        en         = slot & w.drv & gen_en;
        b.slot     = slot;
        b.valid    = en;
        b.sof      = slot & (ch == '0);
        b.local_ch = is_local;
        b.aux      = en & w.aux;
        b.chan     = ch;
        if (!en)
            b.data = '0;
        else if (w.msg)
            b.data = w.ptr[SMP_W-1:0];
        else if (ptr_ok)
            b.data = mem_byte;
        else
            b.data = '0;
        return b;
    endfunction

endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr
    import tsi_pkg::*;
#(
    parameter int NUM_CH = CH_TOTAL
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output chan_t cur
);
    localparam chan_t LAST = chan_t'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (adv)
            cur <= (cur == LAST) ? '0 : cur + chan_t'(1);
    end
endmodule

// File: rtl/tsi_ram.sv
module tsi_ram #(
    parameter int DEPTH = 384,
    parameter int W     = 8,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data
);
    localparam logic [AW:0] LIM = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic ra_ok, rb_ok, w_ok;

    generate
        if (DEPTH == (1 << AW)) begin : g_full
            assign ra_ok = 1'b1;
            assign rb_ok = 1'b1;
            assign w_ok  = 1'b1;
        end else begin : g_part
            assign ra_ok = {1'b0, ra_addr} < LIM;
            assign rb_ok = {1'b0, rb_addr} < LIM;
            assign w_ok  = {1'b0, waddr}   < LIM;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we && w_ok) begin
            mem[waddr] <= wdata;
        end
    end

    // Reads return the contents from before any write at this edge.
    assign ra_data = ra_ok ? mem[ra_addr] : '0;
    assign rb_data = rb_ok ? mem[rb_addr] : '0;
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
    import tsi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_strobe,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_sel,
    input  logic [CWORD_W-1:0] cpu_wdata,
    input  sample_t            dm_rdata,
    input  logic [CWORD_W-1:0] cm_rdata,
    output logic               cpu_ready,
    output logic [CWORD_W-1:0] cpu_rdata,
    output logic               dm_we,
    output logic               cm_we,
    output logic               gen_en
);
    cpu_sel_e sel;
    logic     grant;

    assign sel       = cpu_sel_e'(cpu_sel);
    assign grant     = cpu_req & ~in_strobe;
    assign cpu_ready = grant;
    assign dm_we     = grant & cpu_we & (sel == SEL_DATA);
    assign cm_we     = grant & cpu_we & (sel == SEL_CONN);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en    <= 1'b0;
            cpu_rdata <= '0;
        end else if (grant) begin
            if (cpu_we) begin
                if (sel == SEL_CTRL)
                    gen_en <= cpu_wdata[0];
            end else begin
                case (sel)
                    SEL_DATA: cpu_rdata <= {{(CWORD_W-SMP_W){1'b0}}, dm_rdata};
                    SEL_CONN: cpu_rdata <= cm_rdata;
                    SEL_CTRL: cpu_rdata <= {{(CWORD_W-1){1'b0}}, gen_en};
                    default:  cpu_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
    import tsi_pkg::*;
#(
    parameter int BUS_CH = CH_BUS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot,
    input  chan_t      ch,
    input  conn_word_t word,
    input  sample_t    mem_byte,
    input  logic       ptr_ok,
    input  logic       gen_en,
    output out_beat_t  beat_q
);
    localparam logic [PTR_W:0] LOCAL_BASE = (PTR_W+1)'(BUS_CH);

    out_beat_t beat_d;
    logic      is_local;

    assign is_local = {1'b0, ch} >= LOCAL_BASE;

    always_comb begin
        beat_d = make_beat(slot, ch, word, mem_byte, ptr_ok, gen_en, is_local);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (slot) begin
            beat_q <= beat_d;
        end else begin
            beat_q.slot  <= 1'b0;
            beat_q.valid <= 1'b0;
            beat_q.sof   <= 1'b0;
            beat_q.aux   <= 1'b0;
            beat_q.data  <= '0;
        end
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_CH = CH_TOTAL,
    parameter int BUS_CH = CH_BUS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_strobe,
    input  logic [SMP_W-1:0]    in_sample,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [1:0]          cpu_sel,
    input  logic [PTR_W-1:0]    cpu_addr,
    input  logic [CWORD_W-1:0]  cpu_wdata,
    output logic                cpu_ready,
    output logic [CWORD_W-1:0]  cpu_rdata,
    output logic                out_slot,
    output logic                out_valid,
    output logic [PTR_W-1:0]    out_chan,
    output logic                out_sof,
    output logic                out_local,
    output logic                out_aux,
    output logic [SMP_W-1:0]    out_data
);
    localparam logic [PTR_W:0] CH_LIM = (PTR_W+1)'(NUM_CH);

    chan_t              cur_ch;
    logic               gen_en;
    logic               dm_cpu_we, cm_cpu_we;
    sample_t            dm_sw_rd, dm_cpu_rd;
    logic [CWORD_W-1:0] cm_sw_rd, cm_cpu_rd;
    conn_word_t         cur_word;
    logic               ptr_ok;
    out_beat_t          beat;

    tsi_slot_ctr #(.NUM_CH(NUM_CH)) i_ctr (
        .clk (clk),
        .rst (rst),
        .adv (in_strobe),
        .cur (cur_ch)
    );

    // Data memory: the switching write owns the port in strobe cycles.
    tsi_ram #(.DEPTH(NUM_CH), .W(SMP_W), .AW(PTR_W)) i_dmem (
        .clk     (clk),
        .rst     (rst),
        .we      (in_strobe | dm_cpu_we),
        .waddr   (in_strobe ? cur_ch : cpu_addr),
        .wdata   (in_strobe ? in_sample : cpu_wdata[SMP_W-1:0]),
        .ra_addr (cur_word.ptr),
        .ra_data (dm_sw_rd),
        .rb_addr (cpu_addr),
        .rb_data (dm_cpu_rd)
    );

    tsi_ram #(.DEPTH(NUM_CH), .W(CWORD_W), .AW(PTR_W)) i_cmem (
        .clk     (clk),
        .rst     (rst),
        .we      (cm_cpu_we),
        .waddr   (cpu_addr),
        .wdata   (cpu_wdata),
        .ra_addr (cur_ch),
        .ra_data (cm_sw_rd),
        .rb_addr (cpu_addr),
        .rb_data (cm_cpu_rd)
    );

    assign cur_word = conn_word_t'(cm_sw_rd);
    assign ptr_ok   = {1'b0, cur_word.ptr} < CH_LIM;

    tsi_cpu_port i_cpu (
        .clk       (clk),
        .rst       (rst),
        .in_strobe (in_strobe),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .dm_rdata  (dm_cpu_rd),
        .cm_rdata  (cm_cpu_rd),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .dm_we     (dm_cpu_we),
        .cm_we     (cm_cpu_we),
        .gen_en    (gen_en)
    );

    tsi_out_stage #(.BUS_CH(BUS_CH)) i_out (
        .clk      (clk),
        .rst      (rst),
        .slot     (in_strobe),
        .ch       (cur_ch),
        .word     (cur_word),
        .mem_byte (dm_sw_rd),
        .ptr_ok   (ptr_ok),
        .gen_en   (gen_en),
        .beat_q   (beat)
    );

    assign out_slot  = beat.slot;
    assign out_valid = beat.valid;
    assign out_chan  = beat.chan;
    assign out_sof   = beat.sof;
    assign out_local = beat.local_ch;
    assign out_aux   = beat.aux;
    assign out_data  = beat.data;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NUM_CH = 384
) (
    input logic       clk,
    input logic       rst,
    input logic       in_strobe,
    input logic       cpu_req,
    input logic       cpu_ready,
    input logic       out_slot,
    input logic       out_valid,
    input logic [8:0] out_chan,
    input logic       out_sof,
    input logic       out_aux,
    input logic [7:0] out_data,
    input logic       gen_en
);
    a_r9_no_grant_in_slot: assert property (@(posedge clk) disable iff (rst)
        in_strobe |-> !cpu_ready);

    a_r8_grant_when_free: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !in_strobe) |-> cpu_ready);

    a_r1_beat_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        in_strobe |=> out_slot);

    a_r1_no_beat_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !in_strobe |=> (!out_slot && !out_valid));

    a_r1_sof_is_chan_zero: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_slot && out_chan == 9'd0));

    a_r1_chan_steps: assert property (@(posedge clk) disable iff (rst)
        (out_slot && in_strobe) |=>
            (out_chan == (($past(out_chan) == 9'(NUM_CH - 1)) ? 9'd0 : $past(out_chan) + 9'd1)));

    a_r1_chan_in_range: assert property (@(posedge clk) disable iff (rst)
        out_chan < 9'(NUM_CH));

    a_r6_idle_is_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == 8'd0 && !out_aux));

    a_r6_global_off: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !out_valid);
endmodule

bind tsi_switch tsi_switch_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_strobe (in_strobe),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .out_slot  (out_slot),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_sof   (out_sof),
    .out_aux   (out_aux),
    .out_data  (out_data),
    .gen_en    (gen_en)
);

// File: tb/test_tsi_switch.sv
`timescale 1ns/1ps
module test_tsi_switch;
    localparam int NCH = 384;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_strobe = 1'b0;
    logic [7:0]  in_sample = 8'd0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [8:0]  cpu_addr = 9'd0;
    logic [11:0] cpu_wdata = 12'd0;
    logic        cpu_ready;
    logic [11:0] cpu_rdata;
    logic        out_slot, out_valid, out_sof, out_local, out_aux;
    logic [8:0]  out_chan;
    logic [7:0]  out_data;

    tsi_switch i_tsi_switch (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_sample(in_sample),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .out_slot(out_slot), .out_valid(out_valid), .out_chan(out_chan),
        .out_sof(out_sof), .out_local(out_local), .out_aux(out_aux), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [11:0] cm_m [NCH];
    logic [7:0]  dm_m [NCH];
    logic        gen_m;
    int          mslot;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic string tag_for(input int s);
        if (s == 0) return "R1 frame start";
        if (s == 1) return "R5 message byte";
        if (s == 2) return "R6 driver off";
        if (s == 3) return "R7 pointer beyond memory";
        if (s == 20 || s == 30 || s == 40) return "R3 frame ordering";
        if (s >= 256) return "R12 local slot";
        return "R3 connection";
    endfunction

    function automatic logic [7:0] exp_byte(input logic [11:0] w, input logic en);
        if (!en) return 8'd0;
        if (w[10]) return w[7:0];
        if (w[8:0] < 9'(NCH)) return dm_m[w[8:0]];
        return 8'd0;
    endfunction

    // Starts and ends at a falling edge.
    task automatic tick(input logic [7:0] smp, input string tag);
        logic [21:0] expv;
        logic [11:0] w;
        logic en;
        int s;
        s = mslot;
        w = cm_m[s];
        en = w[9] & gen_m;
        expv = {1'b1, 9'(s), (s == 0), (s >= 256), en, en & w[11], exp_byte(w, en)};
        in_strobe = 1'b1;
        in_sample = smp;
        #1;
        if (cpu_req) chk("R9 ready low in strobe cycle", 32'(cpu_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(tag, 32'({out_slot, out_chan, out_sof, out_local, out_valid, out_aux, out_data}), 32'(expv));
        dm_m[s] = smp;
        mslot = (s + 1) % NCH;
    endtask

    task automatic cpu_op(input logic [1:0] sel, input logic we, input int addr,
                          input logic [11:0] wd, output logic [11:0] rd);
        in_strobe = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_sel = sel; cpu_addr = 9'(addr); cpu_wdata = wd;
        #1;
        chk("R8 ready when no strobe", 32'(cpu_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        rd = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) begin
            if (sel == 2'd0 && addr < NCH) dm_m[addr] = wd[7:0];
            if (sel == 2'd1 && addr < NCH) cm_m[addr] = wd;
            if (sel == 2'd2) gen_m = wd[0];
        end
    endtask

    task automatic frame(input string over);
        for (int k = 0; k < NCH; k++) begin
            int s;
            s = mslot;
            tick(8'($urandom), (over == "") ? tag_for(s) : over);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [11:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) begin cm_m[i] = '0; dm_m[i] = '0; end
        gen_m = 1'b0;
        mslot = 0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 outputs after reset",
            32'({out_slot, out_valid, out_chan, out_sof, out_aux, out_data, cpu_ready, cpu_rdata}), 32'd0);
        @(negedge clk);
        cpu_op(2'd1, 1'b0, 7, 12'd0, rd);   chk("R11 connection word cleared", 32'(rd), 32'd0);
        cpu_op(2'd0, 1'b0, 300, 12'd0, rd); chk("R11 data byte cleared", 32'(rd), 32'd0);
        cpu_op(2'd2, 1'b0, 0, 12'd0, rd);   chk("R11 enable cleared", 32'(rd), 32'd0);
        // R6: with everything off, a frame is silent
        frame("R6 global enable off");

        cpu_op(2'd2, 1'b1, 0, 12'h001, rd);
        cpu_op(2'd2, 1'b0, 0, 12'd0, rd);   chk("R8 enable read back", 32'(rd), 32'd1);

        // R4 directed connection words
        cpu_op(2'd1, 1'b1, 0,   {3'b001, 9'd10},  rd);
        cpu_op(2'd1, 1'b1, 1,   {3'b011, 9'h0A5}, rd);
        cpu_op(2'd1, 1'b1, 2,   {3'b100, 9'd3},   rd);
        cpu_op(2'd1, 1'b1, 3,   {3'b001, 9'd450}, rd);
        cpu_op(2'd1, 1'b1, 20,  {3'b001, 9'd30},  rd);
        cpu_op(2'd1, 1'b1, 30,  {3'b101, 9'd20},  rd);
        cpu_op(2'd1, 1'b1, 40,  {3'b001, 9'd40},  rd);
        cpu_op(2'd1, 1'b1, 300, {3'b001, 9'd299}, rd);
        cpu_op(2'd1, 1'b0, 30, 12'd0, rd);  chk("R4 connection word read back", 32'(rd), 32'hA14);
        cpu_op(2'd1, 1'b0, 1, 12'd0, rd);   chk("R4 message word read back", 32'(rd), 32'h6A5);
        cpu_op(2'd0, 1'b1, 10, 12'hF77, rd);
        cpu_op(2'd0, 1'b0, 10, 12'd0, rd);  chk("R8 data byte zero-extended", 32'(rd), 32'h077);

        frame("");
        frame("");
        cpu_op(2'd0, 1'b0, 123, 12'd0, rd); chk("R2 stored sample", 32'(rd), 32'(dm_m[123]));

        // R10: processor data write survives only until the channel's next slot
        cpu_op(2'd0, 1'b1, 5, 12'h03C, rd);
        cpu_op(2'd0, 1'b0, 5, 12'd0, rd);   chk("R10 processor byte visible", 32'(rd), 32'h03C);
        for (int k = 0; k < 6; k++) tick(8'h90 + 8'(k), tag_for(mslot));
        cpu_op(2'd0, 1'b0, 5, 12'd0, rd);   chk("R10 byte replaced by sample", 32'(rd), 32'h095);

        // R9 contention: request raised in a strobe cycle targeting the served channel
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel = 2'd0; cpu_addr = 9'(mslot); cpu_wdata = 12'h0E1;
        begin
            int s;
            s = mslot;
            tick(8'h11, tag_for(s));
            in_strobe = 1'b0;
            #1;
            chk("R9 served after strobe", 32'(cpu_ready), 32'd1);
            @(posedge clk); @(negedge clk);
            cpu_req = 1'b0; cpu_we = 1'b0;
            dm_m[s] = 8'hE1;
            cpu_op(2'd0, 1'b0, s, 12'd0, rd); chk("R9 held write lands after slot", 32'(rd), 32'h0E1);
        end

        // Random connection words for all channels, then full frames
        for (int i = 0; i < NCH; i++) cpu_op(2'd1, 1'b1, i, 12'($urandom), rd);
        frame("");
        frame("");
        cpu_op(2'd2, 1'b1, 0, 12'h000, rd);
        for (int k = 0; k < 40; k++) tick(8'($urandom), "R6 global enable off");
        cpu_op(2'd2, 1'b1, 0, 12'h001, rd);
        frame("");

        finish_run();
    end
endmodule